// File: doc/BRIEF.md
# Programmable Sample-Rate Tick Generator

This block sets the serial timing for one asynchronous serial channel. It divides the system clock in two stages. A prescaler passes the clock through unchanged or divides it by four, and a 16-bit divisor then divides it again. The result is a one-cycle sample enable that the transmitter and receiver use to time their oversampling. The oversampling ratio is 16 or 8 samples per bit, so the divisor for a wanted bit rate is the clock frequency divided by the prescale ratio, the oversampling ratio and the bit rate. For example, a 14.7456 MHz clock in 16x mode with no prescaling gives 921.6 kbit/s with a divisor of 1 and 400 bit/s with a divisor of 2304. With the prescaler at four, a divisor of 1 gives 230.4 kbit/s.

Software loads the divisor as two bytes through separate write strobes. A third strobe loads the two mode bits. Any of these writes restarts the whole counter chain, so a new rate applies from the cycle after the write. The block also drives a one-cycle bit-boundary strobe once per group of samples. It drives a square sample-rate clock that can be routed to a pin, and in 16x mode that clock runs at 16 times the bit rate.

Top module: `baud_gen`

## Requirements
- R1: A synchronous reset drives `tick_o`, `bit_tick_o` and `baud_clk_o` low, clears the divisor to 0 and sets the mode to prescale 1 with 16x oversampling. The outputs stay low until a nonzero divisor is written.
- R2: A write on `wr_div_hi` loads `wdata` into divisor bits 15:8. A write on `wr_div_lo` loads `wdata` into bits 7:0. The other byte is kept.
- R3: For a nonzero divisor D and prescale ratio P, `tick_o` is a one-cycle pulse that repeats every P*D clocks.
- R4: A write on `wr_mode` sets the prescale ratio from `wdata[0]`: 0 selects 1 and 1 selects 4.
- R5: Every strobe on `wr_div_hi`, `wr_div_lo` or `wr_mode` restarts the counters. The first `tick_o` then comes exactly P*D clocks after the write edge, whatever phase the old count had reached.
- R6: While the divisor is 0, `tick_o`, `bit_tick_o` and `baud_clk_o` stay low.
- R7: A write on `wr_mode` sets the oversampling from `wdata[1]`: 1 selects 16 and 0 selects 8. `bit_tick_o` pulses together with every 16th or 8th `tick_o` after a restart, first at 16*P*D or 8*P*D clocks after the write.
- R8: `baud_clk_o` starts high at each restart and goes high again in the same cycle as each `tick_o`. It is high for ceil(D/2)*P clocks of every P*D-clock period. With D=1 it stays high.
- R9: With D=1 and P=1, `tick_o` is high on every clock from the second cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_div_lo | input | 1 | Load divisor low byte from `wdata` |
| wr_div_hi | input | 1 | Load divisor high byte from `wdata` |
| wr_mode | input | 1 | Load mode: `wdata[0]` prescale by 4, `wdata[1]` 16x oversampling |
| wdata | input | 8 | Write data byte |
| tick_o | output | 1 | One-cycle sample enable |
| bit_tick_o | output | 1 | One-cycle bit-boundary enable, coincident with a sample enable |
| baud_clk_o | output | 1 | Square clock at the sample rate |

## Verification
A prescaler phase counter that is off by one shows at once: the first `tick_o` after a restart lands a few clocks early or late, and the following periods are also wrong. A divisor counter that does not restart or does not wrap shows within one P*D period, either as a missing or misplaced tick or as a `baud_clk_o` high time that does not equal ceil(D/2)*P. A wrong oversampling count only shows at the first bit boundary, up to 16 periods after the write. The bench therefore follows each setting until that first `bit_tick_o`.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Mode bits held by the generator
  typedef struct packed {
    logic os16;    // 1: 16 samples per bit, 0: 8 samples per bit
    logic presc4;  // 1: prescale by four, 0: no prescale
  } baud_mode_t;

  localparam baud_mode_t MODE_RESET = '{os16: 1'b1, presc4: 1'b0};

endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_nxt,
  output baud_mode_t        mode_q,
  output baud_mode_t        mode_nxt,
  output logic              restart
);

  localparam int HI_W = DIV_W - BYTE_W;

  // Next values, visible in the same cycle as the write
  always_comb begin
    div_nxt = div_q;
    if (wr_lo) div_nxt[BYTE_W-1:0] = wdata;
    if (wr_hi) div_nxt[DIV_W-1:BYTE_W] = wdata[HI_W-1:0];
    mode_nxt = mode_q;
    if (wr_mode) begin
      mode_nxt.presc4 = wdata[0];
      mode_nxt.os16   = wdata[1];
    end
  end

  assign restart = wr_lo | wr_hi | wr_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      mode_q <= MODE_RESET;
    end else begin
      div_q  <= div_nxt;
      mode_q <= mode_nxt;
    end
  end

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=> (div_q[DIV_W-1:BYTE_W] == $past(div_q[DIV_W-1:BYTE_W]))) else $error("hi byte lost"); // R2

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic sel_div,
  output logic pre_en
);

  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (RATIO > 1) begin : g_div
      logic [PW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == PW'(RATIO - 1));
      assign pre_en = run && (sel_div ? wrap : 1'b1);

      always_ff @(posedge clk) begin
        if (rst || restart || !run || !sel_div) begin
          cnt_q <= '0;
        end else if (wrap) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      AST_PRE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (pre_en && sel_div && !restart) |=> !pre_en) else $error("prescale enable too close"); // R4
    end else begin : g_pass
      assign pre_en = run;
    end
  endgenerate

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_nxt,
  output logic             raw_tick,
  output logic             tick_o,
  output logic             bclk_o
);

  logic [DIV_W-1:0] dc_q;
  logic [DIV_W-1:0] dc_nxt;
  logic [DIV_W:0]   half_nxt;
  logic             at_end;

  assign at_end   = (dc_q == div_q - DIV_W'(1));
  assign raw_tick = pre_en && (div_q != '0) && at_end;
  assign half_nxt = ({1'b0, div_nxt} + 1'b1) >> 1;

  always_comb begin
    if (restart || div_q == '0) begin
      dc_nxt = '0;
    end else if (pre_en) begin
      dc_nxt = at_end ? '0 : dc_q + 1'b1;
    end else begin
      dc_nxt = dc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dc_q   <= '0;
      tick_o <= 1'b0;
      bclk_o <= 1'b0;
    end else begin
      dc_q   <= dc_nxt;
      tick_o <= raw_tick && !restart;
      bclk_o <= (div_nxt != '0) && ({1'b0, dc_nxt} < half_nxt);
    end
  end

  AST_DC_BOUND: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (dc_q < div_q)) else $error("divider count out of range"); // R3
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_q > DIV_W'(1)) |=> !tick_o) else $error("tick wider than one cycle"); // R3
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick_o) else $error("tick right after restart"); // R5
  AST_BCLK_RISE: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> bclk_o) else $error("clock low on tick"); // R8

endmodule

// File: rtl/baud_bitcount.sv
module baud_bitcount #(
  parameter int OS_HI = 16,
  parameter int OS_LO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic os16,
  input  logic raw_tick,
  output logic bit_tick_o
);

  localparam int SW = $clog2(OS_HI);

  logic [SW-1:0] sc_q;
  logic [SW-1:0] last;

  assign last = os16 ? SW'(OS_HI - 1) : SW'(OS_LO - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      sc_q       <= '0;
      bit_tick_o <= 1'b0;
    end else begin
      bit_tick_o <= raw_tick && (sc_q == last);
      if (raw_tick) sc_q <= (sc_q == last) ? '0 : sc_q + 1'b1;
    end
  end

  AST_SC_LOW_RANGE: assert property (@(posedge clk) disable iff (rst)
    !os16 |-> (sc_q < SW'(OS_LO))) else $error("sample count beyond 8x range"); // R7

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int DIV_W       = 16,
  parameter int PRESC_RATIO = 4,
  parameter int OS_HI       = 16,
  parameter int OS_LO       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_div_lo,
  input  logic              wr_div_hi,
  input  logic              wr_mode,
  input  logic [BYTE_W-1:0] wdata,
  output logic              tick_o,
  output logic              bit_tick_o,
  output logic              baud_clk_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  baud_mode_t       mode_q;
  baud_mode_t       mode_nxt;
  logic             restart;
  logic             pre_en;
  logic             raw_tick;

  baud_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_lo(wr_div_lo), .wr_hi(wr_div_hi), .wr_mode(wr_mode),
    .wdata(wdata), .div_q(div_q), .div_nxt(div_nxt), .mode_q(mode_q),
    .mode_nxt(mode_nxt), .restart(restart)
  );

  baud_prescale #(.RATIO(PRESC_RATIO)) u_presc (
    .clk(clk), .rst(rst), .restart(restart), .run(div_q != '0),
    .sel_div(mode_q.presc4), .pre_en(pre_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .restart(restart), .pre_en(pre_en), .div_q(div_q),
    .div_nxt(div_nxt), .raw_tick(raw_tick), .tick_o(tick_o), .bclk_o(baud_clk_o)
  );

  baud_bitcount #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_bits (
    .clk(clk), .rst(rst), .restart(restart), .os16(mode_q.os16),
    .raw_tick(raw_tick), .bit_tick_o(bit_tick_o)
  );

  AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |-> (!tick_o && !bit_tick_o && !baud_clk_o)) else $error("activity with zero divisor"); // R6
  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_tick_o |-> tick_o) else $error("bit boundary without tick"); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_mode |=> (mode_q == $past(mode_q))) else $error("mode changed without write"); // R4

endmodule

// File: tb/tb_baud_gen.sv
module tb_baud_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_div_lo = 1'b0;
  logic       wr_div_hi = 1'b0;
  logic       wr_mode = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick_o, bit_tick_o, baud_clk_o;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  baud_gen dut (
    .clk(clk), .rst(rst), .wr_div_lo(wr_div_lo), .wr_div_hi(wr_div_hi),
    .wr_mode(wr_mode), .wdata(wdata), .tick_o(tick_o),
    .bit_tick_o(bit_tick_o), .baud_clk_o(baud_clk_o)
  );

  typedef struct packed {
    logic        p4;
    logic        os16;
    logic [15:0] div;
    logic [19:0] per;   // expected P*D
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 16'd1,    20'd1},
    '{1'b0, 1'b1, 16'd2,    20'd2},
    '{1'b0, 1'b1, 16'd5,    20'd5},
    '{1'b1, 1'b1, 16'd1,    20'd4},
    '{1'b1, 1'b1, 16'd3,    20'd12},
    '{1'b0, 1'b0, 16'd6,    20'd6},
    '{1'b1, 1'b0, 16'd258,  20'd1032},
    '{1'b0, 1'b1, 16'd2304, 20'd2304}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe one write; returns at the negedge after the write edge (n = 0)
  task automatic wr(input int kind, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    wr_div_lo = (kind == 0);
    wr_div_hi = (kind == 1);
    wr_mode   = (kind == 2);
    @(negedge clk);
    wr_div_lo = 1'b0;
    wr_div_hi = 1'b0;
    wr_mode   = 1'b0;
  endtask

  // Observe from n = 0 up to the first bit boundary
  task automatic measure(input int per, input int os, input int p, input int d,
                         input string tag);
    int first_tick = -1;
    int first_bit = -1;
    int ticks = 0;
    int hi_cnt = 0;
    for (int n = 0; n <= os * per + 1; n++) begin
      if (n > 0) @(negedge clk);
      if (tick_o && first_tick < 0) first_tick = n;
      if (tick_o && n <= os * per) ticks++;
      if (bit_tick_o && first_bit < 0) first_bit = n;
      if (n < per && baud_clk_o) hi_cnt++;
    end
    chk({tag, " R3 R5 first tick"}, first_tick, per);
    chk({tag, " R3 ticks to bit"}, ticks, os);
    chk({tag, " R7 first bit tick"}, first_bit, os * per);
    chk({tag, " R8 clock high time"}, hi_cnt, ((d + 1) / 2) * p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 tick after reset", int'(tick_o), 0);
    chk("R1 bit after reset", int'(bit_tick_o), 0);
    chk("R1 clock after reset", int'(baud_clk_o), 0);
    // R6: zero divisor stays silent
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt += int'(tick_o) + int'(bit_tick_o) + int'(baud_clk_o);
    end
    chk("R6 no activity at divisor 0", cnt, 0);

    // Table of settings: mode, high byte, low byte (R2, R4, R7, R9)
    for (int v = 0; v < NV; v++) begin
      int p;
      int os;
      p  = VECS[v].p4 ? 4 : 1;
      os = VECS[v].os16 ? 16 : 8;
      wr(2, {6'b0, VECS[v].os16, VECS[v].p4});
      wr(1, VECS[v].div[15:8]);
      wr(0, VECS[v].div[7:0]);
      measure(int'(VECS[v].per), os, p, int'(VECS[v].div), $sformatf("vec%0d R2 R4", v));
    end

    // R9: divisor 1, prescale 1: tick every cycle
    wr(2, 8'h02);
    wr(1, 8'h00);
    wr(0, 8'h01);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cnt += int'(tick_o);
    end
    chk("R9 tick on every clock", cnt, 20);

    // R5: restart mid-period
    wr(0, 8'd10);
    repeat (4) @(negedge clk);
    wr(0, 8'd10);
    cnt = -1;
    for (int n = 0; n <= 12; n++) begin
      if (n > 0) @(negedge clk);
      if (tick_o && cnt < 0) cnt = n;
    end
    chk("R5 tick after mid-period rewrite", cnt, 10);

    // R6: divisor back to zero silences everything
    wr(0, 8'd0);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      cnt += int'(tick_o) + int'(bit_tick_o) + int'(baud_clk_o);
      @(negedge clk);
    end
    chk("R6 quiet after zero write", cnt, 0);

    // R1: reset mid-run, then default mode (prescale 1, 16x)
    wr(2, 8'h01);
    wr(0, 8'd7);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cnt += int'(tick_o) + int'(bit_tick_o) + int'(baud_clk_o);
    end
    chk("R1 quiet after reset mid-run", cnt, 0);
    wr(0, 8'd3);
    measure(3, 16, 1, 3, "R1 R4 default mode");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule